// File: doc/BRIEF.md
# Isolated Digital I/O Register Controller

This block is the register side of a digital I/O card with sixteen output drivers and sixteen isolated inputs. A byte-wide bus slave exposes two output latches that can be read back, two input ports, and an interrupt that fires on any input transition. Control is through access side effects rather than through written data. Reading one fixed address arms the interrupt and writing it disarms it. Reading another address turns the input filters on and writing it turns them off. A write to the low input port address clears a pending interrupt.

Inputs pass through a synchronizer and an optional stability filter before edge detection. A change on either edge of any input sets a per-bank flag and a pending flag, as long as the interrupt is armed. The interrupt output is the pending flag gated by the arm bit.

Top module: `dio_reg_block`

## Requirements
- R1: After reset, the output pins are all zero, the interrupt output is low, and a read of the status address (6) returns 0.
- R2: A write to address 0 drives output pins 7..0 and a write to address 4 drives pins 15..8. A read of either address returns the byte last written there, and writing one bank leaves the other unchanged.
- R3: A read of address 1 returns inputs 7..0 and a read of address 5 returns inputs 15..8, in both cases after synchronization.
- R4: A write to address 1 clears all status bits, whatever the data written.
- R5: A read of address 2 arms the interrupt and a write to address 2 disarms it. The interrupt output equals pending AND armed. Input changes that occur while the interrupt is disarmed are not recorded.
- R6: Both rising and falling input edges are detected. Status bit 0 marks a change in inputs 7..0, bit 1 marks a change in inputs 15..8, and bit 2 is the pending flag. All three bits stay set until cleared.
- R7: After reset the filters are off. A read of address 3 turns the filters on and a write to address 3 turns them off. With the filters on, an input level must hold for 4 clocks before it is accepted, so a 2-clock pulse is ignored. With the filters off, the same pulse is detected.
- R8: Writes to addresses 5 and 6 change neither the outputs nor the status.
- R9: When an input edge and a clear write land in the same cycle, the edge wins and the interrupt remains pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register address |
| busWrData | input | 8 | Write data |
| busRd | input | 1 | Read strobe, one access per cycle |
| busWr | input | 1 | Write strobe, one access per cycle |
| busRdData | output | 8 | Read data, valid the cycle after the read strobe |
| inPins | input | 16 | Isolated input levels |
| outPins | output | 16 | Output driver levels |
| irqOut | output | 1 | Active-high interrupt |

## Verification
The bench builds the block with its default parameters: 8-bit banks, a two-stage synchronizer and a 4-clock filter window. With these values the filter window is short enough that a 2-clock pulse can be placed just under the acceptance threshold, and the same pulse can then be shown to pass once the filters are off. The fixed synchronizer depth lets the bench time a clear write so that it lands in exactly the cycle the change detector fires, which exercises the edge-wins rule.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int ADDR_W = 3;

  // Address decode values; the bus map depends on these positions.
  typedef enum logic [ADDR_W-1:0] {
    A_OUT_LO = 3'd0,
    A_IN_LO  = 3'd1,
    A_IRQ    = 3'd2,
    A_FILT   = 3'd3,
    A_OUT_HI = 3'd4,
    A_IN_HI  = 3'd5,
    A_STAT   = 3'd6,
    A_NONE   = 3'd7
  } regAddr_e;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_OUT_LO,
    RD_OUT_HI,
    RD_IN_LO,
    RD_IN_HI,
    RD_STAT
  } rdSel_e;

  // Strobes from control to datapath, valid for one accepted access.
  typedef struct packed {
    logic [1:0] wrOut;
    logic       clrPend;
    logic       irqOn;
    logic       irqOff;
    logic       filtOn;
    logic       filtOff;
    logic       rdEn;
    rdSel_e     rdSel;
  } ctrlStrb_t;
endpackage

// File: rtl/dio_ctrl.sv
module dio_ctrl
  import dio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output ctrlStrb_t         strb
);
  regAddr_e addrE;
  logic     rdAcc;

  assign addrE = regAddr_e'(busAddr);
  // A write takes precedence if both strobes are asserted together.
  assign rdAcc = busRd & ~busWr;

  always_comb begin
    strb = '0;
    strb.rdSel = RD_ZERO;
    strb.rdEn = rdAcc;
    if (busWr) begin
      unique case (addrE)
        A_OUT_LO: strb.wrOut[0] = 1'b1;
        A_OUT_HI: strb.wrOut[1] = 1'b1;
        A_IN_LO:  strb.clrPend  = 1'b1;
        A_IRQ:    strb.irqOff   = 1'b1;
        A_FILT:   strb.filtOff  = 1'b1;
        default:  ;
      endcase
    end else if (rdAcc) begin
      unique case (addrE)
        A_OUT_LO: strb.rdSel = RD_OUT_LO;
        A_OUT_HI: strb.rdSel = RD_OUT_HI;
        A_IN_LO:  strb.rdSel = RD_IN_LO;
        A_IN_HI:  strb.rdSel = RD_IN_HI;
        A_STAT:   strb.rdSel = RD_STAT;
        A_IRQ:    strb.irqOn = 1'b1;
        A_FILT:   strb.filtOn = 1'b1;
        default:  ;
      endcase
    end
  end

  // R8: each access triggers at most one side effect.
  p_one_action_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrOut, strb.clrPend, strb.irqOn, strb.irqOff, strb.filtOn, strb.filtOff}));

  // R8: writes to the upper input port and the status address have no effect.
  p_ignored_wr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && (busAddr == 3'd5 || busAddr == 3'd6)) |->
      ({strb.wrOut, strb.clrPend, strb.irqOn, strb.irqOff, strb.filtOn, strb.filtOff} == '0));
endmodule

// File: rtl/dio_datapath.sv
module dio_datapath
  import dio_pkg::*;
#(
  parameter int BANK_W   = 8,
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrb_t           strb,
  input  logic [BANK_W-1:0]   wrData,
  input  logic [2*BANK_W-1:0] inPins,
  output logic [2*BANK_W-1:0] outPins,
  output logic [BANK_W-1:0]   rdData,
  output logic                irqOut
);
  localparam int IO_W  = 2 * BANK_W;
  localparam int NBANK = 2;
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [BANK_W-1:0] outLat [NBANK];
  logic [IO_W-1:0]   syncStg [SYNC_LEN];
  logic [IO_W-1:0]   synced, acc, accQ, chg;
  logic [NBANK-1:0]  bankChg, bankFlag, setFlag;
  logic              filtEn, irqEn, pending, setPend;

  // Output latches, one per bank.
  for (genvar b = 0; b < NBANK; b++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rstN) outLat[b] <= '0;
      else if (strb.wrOut[b]) outLat[b] <= wrData;
    end
    assign outPins[b*BANK_W +: BANK_W] = outLat[b];

    // R2: a write lands on its own bank's pins in the next cycle.
    p_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
      strb.wrOut[b] |=> outPins[b*BANK_W +: BANK_W] == $past(wrData));
  end

  // Input synchronizer.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_LEN; s++) syncStg[s] <= '0;
    end else begin
      syncStg[0] <= inPins;
      for (int s = 1; s < SYNC_LEN; s++) syncStg[s] <= syncStg[s-1];
    end
  end
  assign synced = syncStg[SYNC_LEN-1];

  always_ff @(posedge clk) begin
    if (!rstN) filtEn <= 1'b0;
    else if (strb.filtOn) filtEn <= 1'b1;
    else if (strb.filtOff) filtEn <= 1'b0;
  end

  // Per-input stability filter.
  for (genvar i = 0; i < IO_W; i++) begin : g_filt
    logic [CNT_W-1:0] cnt;
    logic             accBit;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt <= '0;
        accBit <= 1'b0;
      end else if (!filtEn) begin
        cnt <= '0;
        accBit <= synced[i];
      end else if (synced[i] == accBit) begin
        cnt <= '0;
      end else if (cnt == CNT_W'(FILT_LEN - 1)) begin
        cnt <= '0;
        accBit <= synced[i];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
    assign acc[i] = accBit;
  end

  // Change detection on both edges.
  always_ff @(posedge clk) begin
    if (!rstN) accQ <= '0;
    else accQ <= acc;
  end
  assign chg = acc ^ accQ;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bankChg[b] = |chg[b*BANK_W +: BANK_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqEn <= 1'b0;
    else if (strb.irqOn) irqEn <= 1'b1;
    else if (strb.irqOff) irqEn <= 1'b0;
  end

  assign setFlag = irqEn ? bankChg : '0;
  assign setPend = |setFlag;

  // Sticky status; a new edge outranks a simultaneous clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankFlag <= '0;
      pending <= 1'b0;
    end else if (strb.clrPend) begin
      bankFlag <= setFlag;
      pending <= setPend;
    end else begin
      bankFlag <= bankFlag | setFlag;
      pending <= pending | setPend;
    end
  end

  assign irqOut = pending & irqEn;

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (strb.rdEn) begin
      rdData <= '0;
      unique case (strb.rdSel)
        RD_OUT_LO: rdData <= outLat[0];
        RD_OUT_HI: rdData <= outLat[1];
        RD_IN_LO:  rdData <= acc[0 +: BANK_W];
        RD_IN_HI:  rdData <= acc[BANK_W +: BANK_W];
        RD_STAT:   rdData[2:0] <= {pending, bankFlag};
        default:   ;
      endcase
    end
  end

  // R4: a clear with no concurrent change empties the status.
  p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrPend && !(|bankChg)) |=> (!pending && bankFlag == '0));

  // R5: disarming drops the interrupt output at once.
  p_disarm_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.irqOff |=> !irqOut);

  // R5: nothing becomes pending while disarmed.
  p_no_latch_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEn && !pending) |=> !pending);

  // R6: pending holds until a clear.
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !strb.clrPend) |=> pending);

  // R9: an edge coinciding with a clear keeps the interrupt pending.
  p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrPend && irqEn && (|bankChg)) |=> pending);
endmodule

// File: rtl/dio_reg_block.sv
module dio_reg_block
  import dio_pkg::*;
#(
  parameter int BANK_W   = 8,
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [BANK_W-1:0]   busWrData,
  input  logic                busRd,
  input  logic                busWr,
  output logic [BANK_W-1:0]   busRdData,
  input  logic [2*BANK_W-1:0] inPins,
  output logic [2*BANK_W-1:0] outPins,
  output logic                irqOut
);
  ctrlStrb_t strb;

  dio_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .strb    (strb)
  );

  dio_datapath #(
    .BANK_W   (BANK_W),
    .SYNC_LEN (SYNC_LEN),
    .FILT_LEN (FILT_LEN)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (busWrData),
    .inPins  (inPins),
    .outPins (outPins),
    .rdData  (busRdData),
    .irqOut  (irqOut)
  );
endmodule

// File: tb/sim_dio_reg_block.sv
module sim_dio_reg_block;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busRdData;
  logic [15:0] inPins = '0;
  logic [15:0] outPins;
  logic        irqOut;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dio_reg_block u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busRd(busRd), .busWr(busWr), .busRdData(busRdData),
    .inPins(inPins), .outPins(outPins), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(posedge clk); @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1;
    @(posedge clk); @(negedge clk);
    busRd = 1'b0;
    d = busRdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tReset();
    logic [7:0] d;
    check("R1 outPins", outPins, 16'h0);
    check("R1 irqOut", irqOut, 1'b0);
    busRead(3'd6, d);
    check("R1 status", d, 8'h00);
  endtask

  task automatic tOutputs();
    logic [7:0] d;
    busWrite(3'd0, 8'hA5);
    check("R2 low pins", outPins, 16'h00A5);
    busWrite(3'd4, 8'h3C);
    check("R2 high pins", outPins, 16'h3CA5);
    busRead(3'd0, d);
    check("R2 readback low", d, 8'hA5);
    busRead(3'd4, d);
    check("R2 readback high", d, 8'h3C);
  endtask

  task automatic tInputs();
    logic [7:0] d;
    inPins = 16'h5AC3;
    waitCyc(8);
    busRead(3'd1, d);
    check("R3 in low", d, 8'hC3);
    busRead(3'd5, d);
    check("R3 in high", d, 8'h5A);
    busRead(3'd6, d);
    check("R5 disarmed edges not kept", d, 8'h00);
  endtask

  task automatic tIrq();
    logic [7:0] d;
    busRead(3'd2, d);
    waitCyc(4);
    check("R5 armed idle", irqOut, 1'b0);
    inPins[0] = ~inPins[0];
    waitCyc(8);
    busRead(3'd6, d);
    check("R6 low bank status", d, 8'h05);
    check("R5 irq on", irqOut, 1'b1);
    busWrite(3'd1, 8'hFF);
    busRead(3'd6, d);
    check("R4 clear", d, 8'h00);
    check("R4 irq off", irqOut, 1'b0);
    inPins[9] = ~inPins[9];
    waitCyc(8);
    busRead(3'd6, d);
    check("R6 high bank status", d, 8'h06);
    busWrite(3'd2, 8'hFF);
    check("R5 disarm drops irq", irqOut, 1'b0);
    busRead(3'd6, d);
    check("R6 sticky while disarmed", d, 8'h06);
    busWrite(3'd1, 8'h00);
    inPins[3] = ~inPins[3];
    waitCyc(8);
    busRead(3'd2, d);
    waitCyc(2);
    check("R5 disarmed edge dropped irq", irqOut, 1'b0);
    busRead(3'd6, d);
    check("R5 disarmed edge dropped status", d, 8'h00);
  endtask

  task automatic tIgnored();
    logic [7:0] d;
    inPins[1] = ~inPins[1];
    waitCyc(8);
    busWrite(3'd6, 8'h00);
    busRead(3'd6, d);
    check("R8 status write ignored", d, 8'h05);
    busWrite(3'd5, 8'h00);
    check("R8 in-high write ignored pins", outPins, 16'h3CA5);
    busRead(3'd6, d);
    check("R8 in-high write ignored status", d, 8'h05);
    busWrite(3'd1, 8'h00);
  endtask

  task automatic tFilter();
    logic [7:0] d;
    logic [7:0] lowNow;
    // filters off since reset: a short pulse is seen
    inPins[2] = ~inPins[2]; waitCyc(2); inPins[2] = ~inPins[2];
    waitCyc(10);
    busRead(3'd6, d);
    check("R7 pulse seen with filter off", d, 8'h05);
    busWrite(3'd1, 8'h00);
    busRead(3'd3, d);
    lowNow = inPins[7:0];
    inPins[2] = ~inPins[2]; waitCyc(2); inPins[2] = ~inPins[2];
    waitCyc(12);
    busRead(3'd6, d);
    check("R7 pulse filtered status", d, 8'h00);
    busRead(3'd1, d);
    check("R7 pulse filtered input", d, lowNow);
    inPins[4] = ~inPins[4];
    waitCyc(14);
    busRead(3'd1, d);
    check("R7 steady change accepted", d, inPins[7:0]);
    busRead(3'd6, d);
    check("R7 steady change status", d, 8'h05);
    busWrite(3'd1, 8'h00);
    busWrite(3'd3, 8'h00);
    inPins[2] = ~inPins[2]; waitCyc(2); inPins[2] = ~inPins[2];
    waitCyc(10);
    busRead(3'd6, d);
    check("R7 filter off again", d, 8'h05);
    busWrite(3'd1, 8'h00);
  endtask

  task automatic tEdgeVsClear();
    logic [7:0] d;
    waitCyc(4);
    busRead(3'd6, d);
    check("R9 precondition", d, 8'h00);
    inPins[6] = ~inPins[6];
    waitCyc(3);
    busWrite(3'd1, 8'h00);
    busRead(3'd6, d);
    check("R9 edge wins status", d, 8'h05);
    check("R9 edge wins irq", irqOut, 1'b1);
  endtask

  initial begin
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(1);
    tReset();
    tOutputs();
    tInputs();
    tIrq();
    tIgnored();
    tFilter();
    tEdgeVsClear();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule